// File: doc/BRIEF.md
# SDRAM Mode-Command Sequencer

This block takes a 32-bit command word from a one-cycle register write and turns it into SDRAM control-pin activity for up to two memory devices that share the command, bank and address pins and have their own chip selects and clock enables. One word picks an operation, picks which devices it goes to, gives a repeat count for auto-refresh and gives the value loaded into the mode register. The block then holds a busy flag in its status word until every command of the sequence has gone out and its minimum spacing has passed.

Software brings memory up by writing a series of words and waiting for busy to fall after each one. The usual order is clock-enable start, precharge-all, a burst of auto-refreshes and a mode-register load. Power-down and self-refresh entry lower the clock enable of the chosen devices, and a later normal or clock-start word raises it again. The spacing after precharge, between refreshes and after a mode load comes from three timing inputs, counted in clock cycles.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While reset is held, both clock enables are low, both chip selects are high, RAS_n/CAS_n/WE_n are all high, the address is zero and the status word is zero.
- R2: A write while the status busy bit (bit 5) is low is accepted. Busy reads high in the cycle after the write edge, and the first pin activity of the sequence appears one cycle after that.
- R3: Command word bits [2:0] select the operation: 0 normal, 1 clock-enable start, 2 precharge all, 3 auto-refresh, 4 load mode register, 5 self-refresh entry, 6 power-down entry, 7 reserved. Pins (RAS_n,CAS_n,WE_n) carry 010 for precharge, 001 for refresh, 000 for mode load and 111 for no command.
- R4: Word bit 4 targets device 0 (chip select 0, clock enable 0) and bit 3 targets device 1. Either, both or neither may be set. A device that is not targeted keeps its chip select high and its clock enable unchanged.
- R5: Auto-refresh issues (bits [8:5] + 1) refresh commands. Consecutive commands are max(t_rc,1) cycles apart, and busy falls max(t_rc,1) cycles after the last one.
- R6: Precharge-all drives address bit 10 high and all other address bits low. Busy falls max(t_rp,1) cycles after the command.
- R7: Mode load drives word bits [9+ADDR_W-1:9] onto the address pins (burst length in payload bits [2:0], CAS latency from payload bit 4) with the bank pins zero. Busy falls max(t_mrd,1) cycles after the command.
- R8: Normal and clock-enable start raise the clock enable of the targeted devices and issue no command. Busy falls one cycle after the enable changes.
- R9: Self-refresh entry issues the refresh pattern with the targeted clock enables lowered in the same cycle. Power-down entry lowers them with no command. Both clear busy after one cycle.
- R10: A write while busy is ignored and sets the sticky error bit (status bit 6). The bit stays set until reset.
- R11: Mode 7 issues no command, changes no clock enable and clears busy after one cycle.
- R12: Whenever busy is low, the command pins are 111 and both chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle write strobe for the command word |
| cmd_wdata | input | 32 | Command word |
| t_rp | input | TW | Cycles after precharge-all |
| t_rc | input | TW | Cycles between refreshes |
| t_mrd | input | TW | Cycles after a mode load |
| status | output | 32 | Bit 5 busy, bit 6 sticky error, rest zero |
| mem_cke | output | 2 | Clock enable per device |
| mem_cs_n | output | 2 | Chip select per device, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address (zero for all commands issued) |
| mem_addr | output | ADDR_W | Address pins |

## Verification
The bench uses the default ADDR_W of 13, so a mode payload spans word bits 9 to 21 and address bit 10 exists for precharge. With TW of 4 and timing inputs drawn from 0 to 6, the zero-spacing boundary (treated as one cycle), back-to-back refreshes and long refresh bursts of up to 16 commands are all reachable. Random words also set bits above the payload, which must have no effect.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int TGT0_BIT    = 4;
  localparam int TGT1_BIT    = 3;
  localparam int CNT_LSB     = 5;
  localparam int CNT_W       = 4;
  localparam int PAYLOAD_LSB = 9;
  localparam int STAT_BUSY   = 5;
  localparam int STAT_ERR    = 6;
  localparam int NDEV        = 2;
  localparam int PRE_ALL_BIT = 10;

  typedef enum logic [2:0] {
    MD_NORMAL     = 3'd0,
    MD_CLK_START  = 3'd1,
    MD_PRECHARGE  = 3'd2,
    MD_REFRESH    = 3'd3,
    MD_LOAD_MODE  = 3'd4,
    MD_SELF_REF   = 3'd5,
    MD_POWER_DOWN = 3'd6,
    MD_RESERVED   = 3'd7
  } mode_e;

  typedef enum logic [1:0] {OP_NOP, OP_PRE, OP_REF, OP_MRS} op_e;
  typedef enum logic [1:0] {CK_KEEP, CK_RAISE, CK_LOWER} cke_act_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t op_pins(op_e op);
    pins_t p;
    case (op)
      OP_PRE:  p = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      OP_REF:  p = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      OP_MRS:  p = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int TW     = 4,
  localparam int WORD_W = PAYLOAD_LSB + ADDR_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_rc,
  input  logic [TW-1:0]     t_mrd,
  output op_e               op,
  output logic [TW-1:0]     gap,
  output logic [CNT_W-1:0]  extra,
  output cke_act_e          cke_act,
  output logic [NDEV-1:0]   tgt,
  output logic [ADDR_W-1:0] addr_val
);

  function automatic logic [TW-1:0] at_least_one(logic [TW-1:0] t);
    return (t == '0) ? TW'(1) : t;
  endfunction

  mode_e mode;
  assign mode = mode_e'(word[2:0]);
  assign tgt  = {word[TGT1_BIT], word[TGT0_BIT]};

  always_comb begin
    op       = OP_NOP;
    gap      = TW'(1);
    extra    = '0;
    cke_act  = CK_KEEP;
    addr_val = '0;
    case (mode)
      MD_NORMAL, MD_CLK_START: cke_act = CK_RAISE;
      MD_PRECHARGE: begin
        op                    = OP_PRE;
        gap                   = at_least_one(t_rp);
        addr_val[PRE_ALL_BIT] = 1'b1;
      end
      MD_REFRESH: begin
        op    = OP_REF;
        gap   = at_least_one(t_rc);
        extra = word[CNT_LSB +: CNT_W];
      end
      MD_LOAD_MODE: begin
        op       = OP_MRS;
        gap      = at_least_one(t_mrd);
        addr_val = word[PAYLOAD_LSB +: ADDR_W];
      end
      MD_SELF_REF: begin
        op      = OP_REF;
        cke_act = CK_LOWER;
      end
      MD_POWER_DOWN: cke_act = CK_LOWER;
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val - TW'(1);
    else if (!expired) cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sdram_cke_bank.sv
module sdram_cke_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [N-1:0] tgt,
  input  logic         val,
  output logic [N-1:0] cke
);

  for (genvar i = 0; i < N; i++) begin : g_dev
    logic cke_q;
    logic cke_en;
    assign cke_en = upd && tgt[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cke_q <= 1'b0;
      else if (cke_en) cke_q <= val;
    end
    assign cke[i] = cke_q;
  end

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int TW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_wdata,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_rc,
  input  logic [TW-1:0]     t_mrd,
  output logic [31:0]       status,
  output logic [1:0]        mem_cke,
  output logic [1:0]        mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam int WORD_W = PAYLOAD_LSB + ADDR_W;

  state_e              state_q, state_d;
  logic [WORD_W-1:0]   word_q;
  logic                word_en;
  logic [CNT_W-1:0]    reps_q, reps_d;
  logic                err_q, err_d;
  pins_t               pins_q, pins_d;
  logic [NDEV-1:0]     cs_n_q, cs_n_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                busy;

  op_e                 dec_op;
  logic [TW-1:0]       dec_gap;
  logic [CNT_W-1:0]    dec_extra;
  cke_act_e            dec_cke_act;
  logic [NDEV-1:0]     dec_tgt;
  logic [ADDR_W-1:0]   dec_addr;

  logic                tmr_load;
  logic                tmr_expired;
  logic                cke_upd;

  logic                unused_wdata;
  assign unused_wdata = ^cmd_wdata[31:WORD_W];

  sdram_cmd_decode #(.ADDR_W(ADDR_W), .TW(TW)) u_decode (
    .word     (word_q),
    .t_rp     (t_rp),
    .t_rc     (t_rc),
    .t_mrd    (t_mrd),
    .op       (dec_op),
    .gap      (dec_gap),
    .extra    (dec_extra),
    .cke_act  (dec_cke_act),
    .tgt      (dec_tgt),
    .addr_val (dec_addr)
  );

  sdram_gap_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (dec_gap),
    .expired  (tmr_expired)
  );

  sdram_cke_bank #(.N(NDEV)) u_cke (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (cke_upd),
    .tgt   (dec_tgt),
    .val   (dec_cke_act == CK_RAISE),
    .cke   (mem_cke)
  );

  assign busy    = (state_q != ST_IDLE);
  assign word_en = (state_q == ST_IDLE) && cmd_wr;

  always_comb begin
    state_d  = state_q;
    reps_d   = reps_q;
    err_d    = err_q;
    pins_d   = op_pins(OP_NOP);
    cs_n_d   = '1;
    addr_d   = '0;
    tmr_load = 1'b0;
    cke_upd  = 1'b0;
    if (cmd_wr && busy) err_d = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (cmd_wr) state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        pins_d   = op_pins(dec_op);
        cs_n_d   = (dec_op == OP_NOP) ? '1 : ~dec_tgt;
        addr_d   = dec_addr;
        tmr_load = 1'b1;
        reps_d   = dec_extra;
        cke_upd  = (dec_cke_act != CK_KEEP);
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_expired) begin
          if (reps_q != '0) begin
            pins_d   = op_pins(OP_REF);
            cs_n_d   = ~dec_tgt;
            addr_d   = dec_addr;
            tmr_load = 1'b1;
            reps_d   = reps_q - CNT_W'(1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      reps_q  <= '0;
      err_q   <= 1'b0;
      pins_q  <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      cs_n_q  <= '1;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      reps_q  <= reps_d;
      err_q   <= err_d;
      pins_q  <= pins_d;
      cs_n_q  <= cs_n_d;
      addr_q  <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= cmd_wdata[WORD_W-1:0];
  end

  always_comb begin
    status            = '0;
    status[STAT_BUSY] = busy;
    status[STAT_ERR]  = err_q;
  end

  assign mem_cs_n  = cs_n_q;
  assign mem_ras_n = pins_q.ras_n;
  assign mem_cas_n = pins_q.cas_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_addr  = addr_q;
  assign mem_ba    = '0;

endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic [31:0]       status,
  input logic [1:0]        mem_cke,
  input logic [1:0]        mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr
);

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[5] && cmd_wr) |=> status[5]); // R2

  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && cmd_wr) |=> status[6]); // R10

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |=> status[6]); // R10

  AST_PRECHARGE_A10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ras_n && mem_cas_n && !mem_we_n) |-> mem_addr[10]); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !status[5] |-> (mem_ras_n && mem_cas_n && mem_we_n && mem_cs_n == 2'b11)); // R12

  AST_CKE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_cke) |-> status[5]); // R8

endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .status    (status),
  .mem_cke   (mem_cke),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr)
);

// File: tb/tb_sdram_cmd_issuer.sv
`timescale 1ns/1ps
module tb_sdram_cmd_issuer;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int TW     = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_wr;
  logic [31:0]       cmd_wdata;
  logic [TW-1:0]     t_rp, t_rc, t_mrd;
  logic [31:0]       status;
  logic [1:0]        mem_cke, mem_cs_n;
  logic              mem_ras_n, mem_cas_n, mem_we_n;
  logic [BA_W-1:0]   mem_ba;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  logic [1:0] cke_exp;
  logic       err_exp;

  always #2.5 clk = ~clk;

  sdram_cmd_issuer #(.ADDR_W(ADDR_W), .BA_W(BA_W), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .t_rp(t_rp), .t_rc(t_rc), .t_mrd(t_mrd), .status(status),
    .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
    .mem_addr(mem_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int at_least_one(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic string req_of(input int m);
    case (m)
      2: return "R6";
      3: return "R5";
      4: return "R7";
      5, 6: return "R9";
      7: return "R11";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] mk(input int mode, input bit d0, input bit d1,
                                     input int cnt, input int payload);
    return (32'(payload) << 9) | (32'(cnt & 15) << 5) | (32'(d0) << 4) |
           (32'(d1) << 3) | 32'(mode & 7);
  endfunction

  // Issues one word; optionally injects a second write at negedge inj_k.
  task automatic run_cmd(input logic [31:0] w, input int inj_k, input logic [31:0] w2);
    int mode = int'(w[2:0]);
    int g = 1, n = 1, exp_cmds = 0, seen = 0, clear_k = 0;
    logic [2:0] exp_pat = 3'b111;
    logic [ADDR_W-1:0] exp_addr = '0;
    logic [1:0] tg = {w[3], w[4]};
    logic [1:0] exp_cs = ~tg;
    string rq = req_of(mode);
    case (mode)
      2: begin g = at_least_one(int'(t_rp)); exp_cmds = 1; exp_pat = 3'b010;
               exp_addr = ADDR_W'(1) << 10; end
      3: begin g = at_least_one(int'(t_rc)); n = int'(w[8:5]) + 1; exp_cmds = n;
               exp_pat = 3'b001; end
      4: begin g = at_least_one(int'(t_mrd)); exp_cmds = 1; exp_pat = 3'b000;
               exp_addr = w[9 +: ADDR_W]; end
      5: begin exp_cmds = 1; exp_pat = 3'b001; end
      default: ;
    endcase
    if (mode == 0 || mode == 1) cke_exp = cke_exp | tg;
    if (mode == 5 || mode == 6) cke_exp = cke_exp & ~tg;
    if (inj_k != 0) err_exp = 1'b1;

    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(status[5] == 1'b1, "R2", "busy after accept", int'(status[5]), 1);
    for (int k = 2; k < 600 && clear_k == 0; k++) begin
      @(negedge clk);
      cmd_wr = (k == inj_k);
      cmd_wdata = w2;
      if ({mem_ras_n, mem_cas_n, mem_we_n} != 3'b111) begin
        check(k == 2 + seen * g, rq, "command cycle", k, 2 + seen * g);
        if (seen == 0) begin
          check({mem_ras_n, mem_cas_n, mem_we_n} == exp_pat, "R3", "pin pattern",
                int'({mem_ras_n, mem_cas_n, mem_we_n}), int'(exp_pat));
          check(mem_cs_n == exp_cs, "R4", "chip selects", int'(mem_cs_n), int'(exp_cs));
          check(mem_addr == exp_addr, rq, "address", int'(mem_addr), int'(exp_addr));
          check(mem_ba == '0, "R7", "bank pins", int'(mem_ba), 0);
          if (mode == 5)
            check((mem_cke & tg) == 2'b00, "R9", "cke low with entry",
                  int'(mem_cke & tg), 0);
        end
        seen++;
      end
      if (!status[5]) clear_k = k;
    end
    cmd_wr = 1'b0;
    check(seen == exp_cmds, rq, "command count", seen, exp_cmds);
    check(clear_k == 2 + n * g, rq, "busy clear cycle", clear_k, 2 + n * g);
    check(mem_cke == cke_exp, (mode == 5 || mode == 6) ? "R9" : "R4", "clock enables",
          int'(mem_cke), int'(cke_exp));
    check(status[6] == err_exp, "R10", "error bit", int'(status[6]), int'(err_exp));
    check({mem_ras_n, mem_cas_n, mem_we_n, mem_cs_n} == 5'b11111, "R12",
          "idle pins", int'({mem_ras_n, mem_cas_n, mem_we_n, mem_cs_n}), 31);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_cke == 2'b00, "R1", "reset cke", int'(mem_cke), 0);
    check(mem_cs_n == 2'b11, "R1", "reset cs_n", int'(mem_cs_n), 3);
    check({mem_ras_n, mem_cas_n, mem_we_n} == 3'b111, "R1", "reset pins",
          int'({mem_ras_n, mem_cas_n, mem_we_n}), 7);
    check(status == 32'd0, "R1", "reset status", int'(status), 0);
    check(mem_addr == '0, "R1", "reset address", int'(mem_addr), 0);
    rst_n = 1'b1;
    cke_exp = 2'b00; err_exp = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = int'($urandom(32'h5D3A));
    t_rp = 4'd3; t_rc = 4'd5; t_mrd = 4'd2;
    do_reset();

    run_cmd(mk(1, 1, 0, 0, 0), 0, '0);          // R4 device 0 only
    run_cmd(mk(1, 0, 1, 0, 0), 0, '0);          // R8 device 1 joins
    run_cmd(mk(2, 1, 1, 0, 0), 0, '0);          // R6
    run_cmd(mk(3, 1, 1, 7, 0), 0, '0);          // R5 eight refreshes
    run_cmd(mk(4, 1, 1, 0, 'h30), 0, '0);       // R7 CAS 3, burst 1
    run_cmd(mk(5, 0, 1, 0, 0), 0, '0);          // R9 self-refresh dev 1
    run_cmd(mk(0, 0, 1, 0, 0), 0, '0);          // R8 normal again
    run_cmd(mk(6, 1, 1, 0, 0), 0, '0);          // R9 power-down
    run_cmd(mk(0, 1, 1, 0, 0), 0, '0);          // R8
    run_cmd(mk(7, 1, 1, 3, 'h1FFF), 0, '0);     // R11
    t_rc = 4'd0;
    run_cmd(mk(3, 1, 0, 2, 0), 0, '0);          // R5 zero spacing
    t_rc = 4'd6;
    run_cmd(mk(3, 0, 0, 15, 0), 0, '0);         // R4 no target, 16 refreshes
    t_rc = 4'd4;
    run_cmd(mk(3, 1, 1, 3, 0), 3, mk(6, 1, 1, 0, 0)); // R10 ignored write

    for (int i = 0; i < 40; i++) begin
      t_rp  = TW'($urandom_range(0, 6));
      t_rc  = TW'($urandom_range(0, 6));
      t_mrd = TW'($urandom_range(0, 6));
      run_cmd($urandom, 0, '0);
    end

    do_reset();                                 // R10 cleared only by reset
    check(status[6] == 1'b0, "R10", "error after reset", int'(status[6]), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule